// File: doc/BRIEF.md
# Flyback-Referenced Video Timing Measurer

This block runs on the pixel clock and measures where active video sits relative to the horizontal and vertical flyback pulses. Active video is taken from three level-comparator outputs, one each for red, green and blue. Horizontal values are counted in pixel clocks and vertical values in horizontal lines. Every value is 12 bits wide and saturates rather than wrapping.

Each frame runs from one vertical flyback leading edge to the next. During the frame the block gathers the widest horizontal extent of video, the first and last active lines, the line count and the flyback pulse width. On the leading edge that closes the frame, all seven results are copied together into a read-only bank of twelve bytes. A host reads that bank through a byte address, and the results then stay fixed until the next frame closes.

Inputs are assumed to be synchronous to the pixel clock. Within a line, the sample in which the horizontal flyback is first seen low has index 0. A line ends at the next horizontal flyback leading edge.

Top module: `vtm_timing_meas`

## Requirements
- R1: After reset, every byte of the bank reads 0.
- R2: A sample is active when at least one of the red, green or blue comparator inputs is high while the horizontal flyback input is low. Comparator activity while horizontal flyback is high has no effect on any result.
- R3: Horizontal start is the smallest, over the frame's active lines, of the index of the line's first active sample.
- R4: Horizontal end is the smallest, over the frame's active lines, of the number of inactive samples between the line's last active sample and the next horizontal flyback leading edge.
- R5: Horizontal active is the largest, over the frame's active lines, of the span from first to last active sample, both included.
- R6: Horizontal pulse is the number of samples with horizontal flyback high in the last flyback pulse that ended inside the frame.
- R7: Vertical active is the number of horizontal flyback leading edges seen after one vertical flyback leading edge, up to the sample before the next one.
- R8: Vertical start is the number of lines completed after the opening vertical edge before the first active line. Vertical end is the number of lines completed after the last active line up to the closing edge. Vertical start plus vertical end never exceeds vertical active.
- R9: In a frame with no active line, horizontal start, end and active and vertical start and end all read 0.
- R10: Results change only on a vertical flyback leading edge that closes a frame, and all seven change together. The first such edge after reset only opens a frame.
- R11: Every count stops at 4095 instead of wrapping. Byte 11 holds one overflow bit per value equal to 4095 (bit k for value k). Its bit 7 is the OR of those bits.
- R12: The values are indexed 0..6 in this order: horizontal start, end, active, pulse, then vertical start, end, active. Byte k (k = 0..6) is the low 8 bits of value k. Bytes 7 to 10 hold the upper 4 bits in pairs: byte 7+j carries value 2j in bits 3:0 and value 2j+1 in bits 7:4, and bits 7:4 of byte 10 are 0. Addresses 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hflb_i | input | 1 | Horizontal flyback pulse, high during flyback |
| vflb_i | input | 1 | Vertical flyback pulse, high during flyback |
| red_act_i | input | 1 | Red level comparator output |
| grn_act_i | input | 1 | Green level comparator output |
| blu_act_i | input | 1 | Blue level comparator output |
| rd_addr_i | input | 4 | Result byte address |
| rd_data_o | output | 8 | Result byte, combinational from the address |

## Verification
The hardest case to reach from the ports is a count that reaches its 4095 ceiling. Only a line with more than four thousand low samples gets there, and a wrap would show only as a small, plausible number. The bench drives one such line with its first active sample at index 4200. It then checks the clamped start value, the unaffected end and span values, and the packed upper-nibble and overflow bytes. A second subtle case is the frame boundary. The vertical edge is placed on the second sample of a flyback pulse, so the horizontal edge just before it closes the last line of the old frame, while the pulse ending just after it belongs to the new frame.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
  localparam int unsigned CNT_W     = 12;
  localparam int unsigned NUM_MEAS  = 7;
  localparam int unsigned HI_BYTES  = (NUM_MEAS + 1) / 2;
  localparam int unsigned NUM_BYTES = NUM_MEAS + HI_BYTES + 1;

  localparam int IDX_HSTART = 0;
  localparam int IDX_HEND   = 1;
  localparam int IDX_HACT   = 2;
  localparam int IDX_HPULSE = 3;
  localparam int IDX_VSTART = 4;
  localparam int IDX_VEND   = 5;
  localparam int IDX_VACT   = 6;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [NUM_MEAS-1:0][CNT_W-1:0] meas_t;

  localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

  function automatic cnt_t sat_inc(cnt_t x);
    return (x == CNT_MAX) ? x : x + cnt_t'(1);
  endfunction
endpackage

// File: rtl/vtm_in_stage.sv
module vtm_in_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hflb_i,
  input  logic vflb_i,
  input  logic red_i,
  input  logic grn_i,
  input  logic blu_i,
  output logic h_rise_o,
  output logic h_fall_o,
  output logic v_rise_o,
  output logic act_raw_o
);
  logic h_q, v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= 1'b0;
      v_q <= 1'b0;
    end else begin
      h_q <= hflb_i;
      v_q <= vflb_i;
    end
  end

  assign h_rise_o  = hflb_i & ~h_q;
  assign h_fall_o  = ~hflb_i & h_q;
  assign v_rise_o  = vflb_i & ~v_q;
  assign act_raw_o = red_i | grn_i | blu_i;
endmodule

// File: rtl/vtm_line_meas.sv
module vtm_line_meas
  import vtm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic h_i,
  input  logic h_rise_i,
  input  logic h_fall_i,
  input  logic act_raw_i,
  output logic line_done_o,
  output logic line_act_o,
  output cnt_t line_start_o,
  output cnt_t line_end_o,
  output cnt_t line_span_o,
  output logic pulse_done_o,
  output cnt_t pulse_w_o
);
  logic open_q, seen_q, p_open_q;
  cnt_t pos_q, fa_q, span_q, span_last_q, tail_q, pcnt_q;
  cnt_t cur_pos, span_cur;
  logic act, first;

  always_comb begin
    cur_pos  = h_fall_i ? '0 : sat_inc(pos_q);
    act      = act_raw_i & ~h_i & (open_q | h_fall_i);
    first    = act & ~seen_q;
    span_cur = first ? cnt_t'(1) : sat_inc(span_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q      <= 1'b0;
      seen_q      <= 1'b0;
      p_open_q    <= 1'b0;
      pos_q       <= '0;
      fa_q        <= '0;
      span_q      <= '0;
      span_last_q <= '0;
      tail_q      <= '0;
      pcnt_q      <= '0;
    end else begin
      pos_q <= cur_pos;
      if (h_fall_i) open_q <= 1'b1;
      if (h_rise_i) begin
        seen_q <= 1'b0;
        tail_q <= '0;
        span_q <= '0;
      end else if (act) begin
        if (first) begin
          seen_q <= 1'b1;
          fa_q   <= cur_pos;
        end
        span_q      <= span_cur;
        span_last_q <= span_cur;
        tail_q      <= '0;
      end else if (seen_q && !h_i) begin
        span_q <= span_cur;
        tail_q <= sat_inc(tail_q);
      end
      // pulse width: high samples since the leading edge
      if (h_i) pcnt_q <= h_rise_i ? cnt_t'(1) : sat_inc(pcnt_q);
      if (h_rise_i) p_open_q <= 1'b1;
    end
  end

  assign line_done_o  = h_rise_i & open_q;
  assign line_act_o   = seen_q;
  assign line_start_o = fa_q;
  assign line_end_o   = tail_q;
  assign line_span_o  = span_last_q;
  assign pulse_done_o = h_fall_i & p_open_q;
  assign pulse_w_o    = pcnt_q;
endmodule

// File: rtl/vtm_frame_acc.sv
module vtm_frame_acc
  import vtm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  v_rise_i,
  input  logic  line_done_i,
  input  logic  line_act_i,
  input  cnt_t  line_start_i,
  input  cnt_t  line_end_i,
  input  cnt_t  line_span_i,
  input  logic  pulse_done_i,
  input  cnt_t  pulse_w_i,
  output meas_t meas_o
);
  logic  fopen_q, any_q;
  cnt_t  vline_q, hs_q, he_q, ha_q, hp_q, vfirst_q, vlast_q;
  meas_t snap;

  always_comb begin
    snap             = '0;
    snap[IDX_HSTART] = any_q ? hs_q : '0;
    snap[IDX_HEND]   = any_q ? he_q : '0;
    snap[IDX_HACT]   = ha_q;
    snap[IDX_HPULSE] = hp_q;
    snap[IDX_VSTART] = any_q ? vfirst_q : '0;
    snap[IDX_VEND]   = any_q ? vline_q - vlast_q : '0;
    snap[IDX_VACT]   = vline_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fopen_q  <= 1'b0;
      any_q    <= 1'b0;
      vline_q  <= '0;
      hs_q     <= CNT_MAX;
      he_q     <= CNT_MAX;
      ha_q     <= '0;
      hp_q     <= '0;
      vfirst_q <= '0;
      vlast_q  <= '0;
      meas_o   <= '0;
    end else if (v_rise_i) begin
      if (fopen_q) meas_o <= snap;  // one-shot copy keeps frames unmixed
      fopen_q  <= 1'b1;
      any_q    <= 1'b0;
      vline_q  <= '0;
      hs_q     <= CNT_MAX;
      he_q     <= CNT_MAX;
      ha_q     <= '0;
      hp_q     <= '0;
      vfirst_q <= '0;
      vlast_q  <= '0;
    end else begin
      if (line_done_i) begin
        vline_q <= sat_inc(vline_q);
        if (line_act_i) begin
          any_q <= 1'b1;
          if (!any_q) vfirst_q <= vline_q;
          vlast_q <= sat_inc(vline_q);
          if (line_start_i < hs_q) hs_q <= line_start_i;
          if (line_end_i < he_q)   he_q <= line_end_i;
          if (line_span_i > ha_q)  ha_q <= line_span_i;
        end
      end
      if (pulse_done_i) hp_q <= pulse_w_i;
    end
  end
endmodule

// File: rtl/vtm_reg_bank.sv
module vtm_reg_bank
  import vtm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  meas_t             meas_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned HI_SLOTS = 2 * HI_BYTES;

  logic [7:0]          bank [NUM_BYTES];
  logic [3:0]          hi   [HI_SLOTS];
  logic [NUM_MEAS-1:0] ovf;

  for (genvar k = 0; k < HI_SLOTS; k++) begin : g_hi
    if (k < NUM_MEAS) begin : g_val
      assign hi[k]     = 4'(meas_i[k] >> 8);
      assign ovf[k]    = (meas_i[k] == CNT_MAX);
      assign bank[k]   = meas_i[k][7:0];
    end else begin : g_pad
      assign hi[k] = 4'h0;
    end
  end

  for (genvar j = 0; j < HI_BYTES; j++) begin : g_pair
    assign bank[NUM_MEAS+j] = {hi[2*j+1], hi[2*j]};
  end

  assign bank[NUM_BYTES-1] = {|ovf, ovf};

  assign rd_data_o = (rd_addr_i < ADDR_W'(NUM_BYTES)) ? bank[rd_addr_i] : 8'h00;
endmodule

// File: rtl/vtm_timing_meas.sv
module vtm_timing_meas
  import vtm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hflb_i,
  input  logic              vflb_i,
  input  logic              red_act_i,
  input  logic              grn_act_i,
  input  logic              blu_act_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic  h_rise, h_fall, v_rise, act_raw;
  logic  line_done, line_act, pulse_done;
  cnt_t  line_start, line_end, line_span, pulse_w;
  meas_t meas;

  vtm_in_stage u_in (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hflb_i   (hflb_i),
    .vflb_i   (vflb_i),
    .red_i    (red_act_i),
    .grn_i    (grn_act_i),
    .blu_i    (blu_act_i),
    .h_rise_o (h_rise),
    .h_fall_o (h_fall),
    .v_rise_o (v_rise),
    .act_raw_o(act_raw)
  );

  vtm_line_meas u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .h_i         (hflb_i),
    .h_rise_i    (h_rise),
    .h_fall_i    (h_fall),
    .act_raw_i   (act_raw),
    .line_done_o (line_done),
    .line_act_o  (line_act),
    .line_start_o(line_start),
    .line_end_o  (line_end),
    .line_span_o (line_span),
    .pulse_done_o(pulse_done),
    .pulse_w_o   (pulse_w)
  );

  vtm_frame_acc u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .v_rise_i    (v_rise),
    .line_done_i (line_done),
    .line_act_i  (line_act),
    .line_start_i(line_start),
    .line_end_i  (line_end),
    .line_span_i (line_span),
    .pulse_done_i(pulse_done),
    .pulse_w_i   (pulse_w),
    .meas_o      (meas)
  );

  vtm_reg_bank #(.ADDR_W(ADDR_W)) u_bank (
    .meas_i   (meas),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/vtm_timing_meas_chk.sv
module vtm_timing_meas_chk
  import vtm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              v_rise_i,
  input meas_t             meas_i,
  input logic              pulse_done_i,
  input cnt_t              pulse_w_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_i
);
  a_r10_hold_between_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_rise_i |=> $stable(meas_i));

  a_r9_empty_frame_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_i[IDX_HACT] == '0) |-> (meas_i[IDX_HSTART] == '0 && meas_i[IDX_HEND] == '0 &&
                                  meas_i[IDX_VSTART] == '0 && meas_i[IDX_VEND] == '0));

  a_r8_vert_within_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, meas_i[IDX_VSTART]} + {1'b0, meas_i[IDX_VEND]}) <= {1'b0, meas_i[IDX_VACT]});

  a_r11_pulse_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_done_i |-> pulse_w_i != '0);

  a_r12_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= ADDR_W'(NUM_BYTES)) |-> rd_data_i == 8'h00);
endmodule

bind vtm_timing_meas vtm_timing_meas_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .v_rise_i    (v_rise),
  .meas_i      (meas),
  .pulse_done_i(pulse_done),
  .pulse_w_i   (pulse_w),
  .rd_addr_i   (rd_addr_i),
  .rd_data_i   (rd_data_o)
);

// File: tb/vtm_timing_meas_tb_top.sv
module vtm_timing_meas_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hflb_i = 1'b0, vflb_i = 1'b0;
  logic       red_act_i = 1'b0, grn_act_i = 1'b0, blu_act_i = 1'b0;
  logic [3:0] rd_addr_i = 4'd0;
  logic [7:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  int a_st [16];
  int a_ln [16];
  int a_col[16];

  always #4 clk_i = ~clk_i;

  vtm_timing_meas dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hflb_i(hflb_i), .vflb_i(vflb_i),
    .red_act_i(red_act_i), .grn_act_i(grn_act_i), .blu_act_i(blu_act_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit h, bit v, bit r, bit g, bit b);
    @(negedge clk_i);
    hflb_i = h; vflb_i = v; red_act_i = r; grn_act_i = g; blu_act_i = b;
  endtask

  task automatic read_byte(int a, output int d);
    @(negedge clk_i);
    rd_addr_i = 4'(a);
    #1 d = int'(rd_data_o);
  endtask

  task automatic read_meas(int k, output int v);
    int lo, hb;
    read_byte(k, lo);
    read_byte(7 + k / 2, hb);
    v = (((k % 2) != 0) ? (hb >> 4) & 15 : hb & 15) * 256 + lo;
  endtask

  function automatic int sat(int x);
    return (x > 4095) ? 4095 : x;
  endfunction

  task automatic send_line(bit vmark, int pw, int low, int st, int ln, int col, bit fly_act);
    for (int i = 0; i < pw; i++) drive(1'b1, vmark && i >= 1, fly_act, fly_act, 1'b0);
    for (int i = 0; i < low; i++) begin
      bit on;
      on = (ln > 0) && (i >= st) && (i < st + ln);
      drive(1'b0, 1'b0, on && col == 0, on && col == 1, on && col == 2);
    end
  endtask

  task automatic send_frame(int n, int pw, int low, bit fly_act);
    for (int k = 0; k < n; k++)
      send_line(k == 0, pw, low, a_st[k], a_ln[k], a_col[k], fly_act);
  endtask

  task automatic close_frame(int pw);
    send_line(1'b1, pw, 1, 0, 0, 0, 1'b0);
  endtask

  task automatic clear_lines();
    for (int k = 0; k < 16; k++) begin a_st[k] = 0; a_ln[k] = 0; a_col[k] = 0; end
  endtask

  task automatic calc(int n, int pw, int low, output int e[7]);
    int first, last;
    first = -1; last = -1;
    e[0] = 4095; e[1] = 4095; e[2] = 0;
    for (int k = 0; k < n; k++) if (a_ln[k] > 0) begin
      if (first < 0) first = k;
      last = k;
      if (sat(a_st[k]) < e[0]) e[0] = sat(a_st[k]);
      if (sat(low - a_st[k] - a_ln[k]) < e[1]) e[1] = sat(low - a_st[k] - a_ln[k]);
      if (sat(a_ln[k]) > e[2]) e[2] = sat(a_ln[k]);
    end
    e[3] = pw;
    e[6] = sat(n);
    if (first < 0) begin
      e[0] = 0; e[1] = 0; e[4] = 0; e[5] = 0;
    end else begin
      e[4] = first; e[5] = n - 1 - last;
    end
  endtask

  task automatic check_frame(string tag, int e[7]);
    string rq [7];
    int v, ob, eo;
    rq = '{"R3", "R4", "R5", "R6", "R8", "R8", "R7"};
    eo = 0;
    for (int k = 0; k < 7; k++) begin
      read_meas(k, v);
      chk(rq[k], $sformatf("%s value %0d", tag, k), v, e[k]);
      if (e[k] == 4095) eo = eo | (1 << k);
    end
    if (eo != 0) eo = eo | 128;
    read_byte(11, ob);
    chk("R11", $sformatf("%s overflow byte", tag), ob, eo);
  endtask

  // R1 R12: reset state, unmapped addresses
  task automatic t_reset();
    int d;
    for (int a = 0; a < 16; a++) begin
      read_byte(a, d);
      chk((a < 12) ? "R1" : "R12", $sformatf("reset byte %0d", a), d, 0);
    end
  endtask

  // R2..R8 mixed colours; R10 first edge and hold
  task automatic t_basic();
    int e[7];
    int z[7];
    clear_lines();
    a_st[1] = 10; a_ln[1] = 20; a_col[1] = 0;
    a_st[2] = 6;  a_ln[2] = 8;  a_col[2] = 1;
    a_st[4] = 12; a_ln[4] = 30; a_col[4] = 2;
    a_st[5] = 15; a_ln[5] = 5;  a_col[5] = 0;
    send_frame(7, 4, 50, 1'b0);
    z = '{0, 0, 0, 0, 0, 0, 0};
    check_frame("R10 first edge", z);
    close_frame(6);
    calc(7, 4, 50, e);
    check_frame("basic", e);
    clear_lines();
    a_st[0] = 1; a_ln[0] = 45; a_col[0] = 1;
    a_st[1] = 2; a_ln[1] = 44; a_col[1] = 2;
    send_line(1'b0, 3, 60, a_st[0], a_ln[0], a_col[0], 1'b0);
    send_line(1'b0, 9, 60, a_st[1], a_ln[1], a_col[1], 1'b0);
    send_line(1'b0, 3, 10, 0, 0, 0, 1'b0);
    check_frame("R10 hold", e);
  endtask

  // R9 R2: empty frame with comparator activity during flyback
  task automatic t_empty();
    int e[7];
    clear_lines();
    send_frame(5, 3, 30, 1'b1);
    close_frame(6);
    calc(5, 3, 30, e);
    check_frame("R9 R2 empty", e);
  endtask

  // R3 R4 boundary: active from index 0 through the last low sample
  task automatic t_edges();
    int e[7];
    clear_lines();
    a_st[1] = 0; a_ln[1] = 20; a_col[1] = 1;
    send_frame(3, 5, 20, 1'b0);
    close_frame(2);
    calc(3, 5, 20, e);
    check_frame("edges", e);
  endtask

  // R11 R12: start beyond the ceiling, packed nibble byte
  task automatic t_sat();
    int e[7];
    int d;
    clear_lines();
    a_st[0] = 4200; a_ln[0] = 10; a_col[0] = 0;
    send_frame(2, 2, 4300, 1'b0);
    close_frame(3);
    calc(2, 2, 4300, e);
    check_frame("R11 saturate", e);
    read_byte(7, d);
    chk("R12", "nibble byte 7", d, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_empty();
    t_edges();
    t_sat();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule